// File: doc/BRIEF.md
# Synthesizer Divider Settings Interface

This block stores and presents the divide settings for an integer-N frequency synthesizer. A host loads the settings in one of three ways: a serial shift port, an 8-bit parallel data bus with one write strobe per field group, or a set of direct pins. The block then drives a 9-bit M value, a 4-bit A value, a 6-bit R value and an active-low prescaler enable to the divider logic. The dividers, the prescaler and the phase detector sit outside this block.

Two copies of the 20-bit settings word are held, a primary and a secondary. A hop strobe copies the primary into the secondary. The host can therefore stage the next channel in the primary while the dividers run from the secondary, and then switch with a single select line. A separate 8-bit enhancement register can be written from the serial port or from the bus, and its value is presented on its own output.

All host lines are sampled on the system clock. An edge is recognised when a line is seen high on a clock sample after it was seen low on the sample before. Outputs are registered.

Top module: `synth_prog_if`

## Requirements
- R1: The mode inputs pick the interface. `mode_direct`=1 selects direct mode whatever `mode_serial` is. `mode_direct`=0 with `mode_serial`=1 selects serial mode. `mode_direct`=0 with `mode_serial`=0 selects parallel mode.
- R2: In serial mode with `e_wr` low, each rising edge of `sclk` shifts `sdata` into the LSB of the 20-bit primary word and moves the older bits up. The word is ordered MSB to LSB as {prescaler enable, M[8:0], R[5:0], A[3:0]}, so the first bit sent ends in the prescaler enable.
- R3: In serial mode with `e_wr` high, each rising edge of `sclk` shifts `sdata` into the LSB of the 8-bit enhancement register instead, and the primary word is left unchanged.
- R4: In parallel mode, a rising edge of `m1_wr` loads d[7] into the prescaler enable and d[6:0] into M[6:0] of the primary word.
- R5: In parallel mode, a rising edge of `m2_wr` loads d[3:2] into R[5:4] and d[1:0] into M[8:7] of the primary word.
- R6: In parallel mode, a rising edge of `a_wr` loads d[7:4] into R[3:0] and d[3:0] into A[3:0] of the primary word.
- R7: In parallel mode, a rising edge of `e_wr` loads d[7:0] into the enhancement register.
- R8: In serial or parallel mode, a rising edge of `hop_wr` copies the whole primary word into the secondary word.
- R9: In serial mode, `sel_ser`=1 routes the primary word to the outputs and `sel_ser`=0 routes the secondary word. In parallel mode, `sel_par` does the same.
- R10: In direct mode the outputs follow the `dir_*` pins. Every strobe, `sclk` included, is ignored, so the stored words and the enhancement register are the same after leaving direct mode as they were before entering it.
- R11: Synchronous active-high reset clears both words, the enhancement register, the edge history and all outputs to zero.
- R12: Outputs are registered. A change on a host line sampled at one clock edge reaches the outputs at the next edge. If all inputs are held steady, the outputs hold.
- R13: Bus strobes (`m1_wr`, `m2_wr`, `a_wr`) do nothing in serial mode, and `sclk` does nothing in parallel mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_direct | input | 1 | 1 selects direct mode |
| mode_serial | input | 1 | With `mode_direct`=0, 1 selects serial and 0 selects parallel |
| sel_ser | input | 1 | Serial-mode source select, 1 for primary and 0 for secondary |
| sel_par | input | 1 | Parallel-mode source select, 1 for primary and 0 for secondary |
| sclk | input | 1 | Serial shift clock, sampled |
| sdata | input | 1 | Serial data, MSB first |
| e_wr | input | 1 | Enhancement target (serial) or enhancement strobe (parallel) |
| m1_wr | input | 1 | Strobe for prescaler enable and M[6:0] |
| m2_wr | input | 1 | Strobe for R[5:4] and M[8:7] |
| a_wr | input | 1 | Strobe for R[3:0] and A[3:0] |
| hop_wr | input | 1 | Copies primary into secondary |
| d | input | 8 | Parallel data bus |
| dir_pre_n | input | 1 | Direct prescaler enable |
| dir_m | input | 9 | Direct M value |
| dir_r | input | 6 | Direct R value |
| dir_a | input | 4 | Direct A value |
| cnt_pre_n | output | 1 | Prescaler enable, active low (1 bypasses the prescaler) |
| cnt_m | output | 9 | M counter value |
| cnt_r | output | 6 | R counter value |
| cnt_a | output | 4 | A counter value |
| enh_out | output | 8 | Enhancement register contents |

## Verification
The assertions assume that every host line is synchronous to `clk` and is held for at least one clock sample at each level. Under that assumption, a strobe or `sclk` edge is a low sample followed by a high sample. The stimulus drives all inputs on the falling clock edge. Each strobe and `sclk` pulse is held high for two samples and low for two samples, and no two strobes are raised in the same cycle, so no edge is missed or merged. The mode and select lines change only while no pulse is in progress.

// File: rtl/sp_pkg.sv
package sp_pkg;
  parameter int M_W    = 9;
  parameter int A_W    = 4;
  parameter int R_W    = 6;
  parameter int D_W    = 8;
  parameter int ENH_W  = 8;
  localparam int WORD_W = 1 + M_W + R_W + A_W;

  // strobe indices into the edge-detector vector
  localparam int S_SCLK = 0;
  localparam int S_EWR  = 1;
  localparam int S_M1   = 2;
  localparam int S_M2   = 3;
  localparam int S_A    = 4;
  localparam int S_HOP  = 5;
  localparam int N_STB  = 6;

  typedef struct packed {
    logic           pre_n;
    logic [M_W-1:0] m;
    logic [R_W-1:0] r;
    logic [A_W-1:0] a;
  } prog_word_t;

  typedef enum logic [1:0] {IF_PAR = 2'd0, IF_SER = 2'd1, IF_DIR = 2'd2} if_mode_e;

  function automatic if_mode_e decode_mode(input logic dir, input logic ser);
    if (dir)      return IF_DIR;
    else if (ser) return IF_SER;
    else          return IF_PAR;
  endfunction
endpackage

// File: rtl/sp_edge.sv
module sp_edge #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev[i] <= 1'b0;
      else     prev[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev[i];
  end
endmodule

// File: rtl/sp_regs.sv
module sp_regs
  import sp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  if_mode_e         mode,
  input  logic [N_STB-1:0] rise,
  input  logic             sdata,
  input  logic             e_lvl,
  input  logic [D_W-1:0]   d,
  output prog_word_t       prim,
  output prog_word_t       sec,
  output logic [ENH_W-1:0] enh
);
  prog_word_t       prim_nxt, sec_nxt;
  logic [ENH_W-1:0] enh_nxt;
  logic [WORD_W-1:0] prim_v;

  assign prim_v = prim;

  always_comb begin
    prim_nxt = prim;
    sec_nxt  = sec;
    enh_nxt  = enh;
    unique case (mode)
      IF_SER: begin
        if (rise[S_SCLK]) begin
          if (e_lvl) enh_nxt  = {enh[ENH_W-2:0], sdata};
          else       prim_nxt = prog_word_t'({prim_v[WORD_W-2:0], sdata});
        end
        if (rise[S_HOP]) sec_nxt = prim;
      end
      IF_PAR: begin
        if (rise[S_M1]) begin
          prim_nxt.pre_n  = d[7];
          prim_nxt.m[6:0] = d[6:0];
        end
        if (rise[S_M2]) begin
          prim_nxt.r[5:4] = d[3:2];
          prim_nxt.m[8:7] = d[1:0];
        end
        if (rise[S_A]) begin
          prim_nxt.r[3:0] = d[7:4];
          prim_nxt.a      = d[3:0];
        end
        if (rise[S_EWR]) enh_nxt = d[ENH_W-1:0];
        if (rise[S_HOP]) sec_nxt = prim;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prim <= '0;
      sec  <= '0;
      enh  <= '0;
    end else begin
      prim <= prim_nxt;
      sec  <= sec_nxt;
      enh  <= enh_nxt;
    end
  end
endmodule

// File: rtl/sp_outsel.sv
module sp_outsel
  import sp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  if_mode_e         mode,
  input  logic             sel_ser,
  input  logic             sel_par,
  input  prog_word_t       prim,
  input  prog_word_t       sec,
  input  prog_word_t       pins,
  input  logic [ENH_W-1:0] enh,
  output prog_word_t       word_q,
  output logic [ENH_W-1:0] enh_q
);
  prog_word_t word_d;

  always_comb begin
    unique case (mode)
      IF_DIR:  word_d = pins;
      IF_SER:  word_d = sel_ser ? prim : sec;
      default: word_d = sel_par ? prim : sec;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      enh_q  <= '0;
    end else begin
      word_q <= word_d;
      enh_q  <= enh;
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import sp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_direct,
  input  logic             mode_serial,
  input  logic             sel_ser,
  input  logic             sel_par,
  input  logic             sclk,
  input  logic             sdata,
  input  logic             e_wr,
  input  logic             m1_wr,
  input  logic             m2_wr,
  input  logic             a_wr,
  input  logic             hop_wr,
  input  logic [D_W-1:0]   d,
  input  logic             dir_pre_n,
  input  logic [M_W-1:0]   dir_m,
  input  logic [R_W-1:0]   dir_r,
  input  logic [A_W-1:0]   dir_a,
  output logic             cnt_pre_n,
  output logic [M_W-1:0]   cnt_m,
  output logic [R_W-1:0]   cnt_r,
  output logic [A_W-1:0]   cnt_a,
  output logic [ENH_W-1:0] enh_out
);
  if_mode_e         mode;
  logic [N_STB-1:0] lvl, rise;
  prog_word_t       prim, sec, pins, word_q;
  logic [ENH_W-1:0] enh;

  assign mode = decode_mode(mode_direct, mode_serial);

  always_comb begin
    lvl         = '0;
    lvl[S_SCLK] = sclk;
    lvl[S_EWR]  = e_wr;
    lvl[S_M1]   = m1_wr;
    lvl[S_M2]   = m2_wr;
    lvl[S_A]    = a_wr;
    lvl[S_HOP]  = hop_wr;
  end

  assign pins.pre_n = dir_pre_n;
  assign pins.m     = dir_m;
  assign pins.r     = dir_r;
  assign pins.a     = dir_a;

  sp_edge #(.N(N_STB)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (lvl),
    .rise(rise)
  );

  sp_regs u_regs (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .rise (rise),
    .sdata(sdata),
    .e_lvl(e_wr),
    .d    (d),
    .prim (prim),
    .sec  (sec),
    .enh  (enh)
  );

  sp_outsel u_out (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .sel_ser(sel_ser),
    .sel_par(sel_par),
    .prim   (prim),
    .sec    (sec),
    .pins   (pins),
    .enh    (enh),
    .word_q (word_q),
    .enh_q  (enh_out)
  );

  assign cnt_pre_n = word_q.pre_n;
  assign cnt_m     = word_q.m;
  assign cnt_r     = word_q.r;
  assign cnt_a     = word_q.a;
endmodule

// File: rtl/sp_chk.sv
module sp_chk
  import sp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             mode_direct,
  input logic             mode_serial,
  input logic             sel_ser,
  input logic             sel_par,
  input logic             sclk,
  input logic             sdata,
  input logic             e_wr,
  input logic             m1_wr,
  input logic             m2_wr,
  input logic             a_wr,
  input logic             hop_wr,
  input logic [D_W-1:0]   d,
  input logic             dir_pre_n,
  input logic [M_W-1:0]   dir_m,
  input logic [R_W-1:0]   dir_r,
  input logic [A_W-1:0]   dir_a,
  input logic             cnt_pre_n,
  input logic [M_W-1:0]   cnt_m,
  input logic [R_W-1:0]   cnt_r,
  input logic [A_W-1:0]   cnt_a,
  input logic [ENH_W-1:0] enh_out
);
  logic [2:0] age;
  logic       ready;
  logic [D_W+M_W+R_W+A_W+11:0] inv;
  logic [WORD_W+ENH_W-1:0]     outs;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  assign ready = (age >= 3'd3);

  assign inv  = {mode_direct, mode_serial, sel_ser, sel_par, sclk, sdata, e_wr,
                 m1_wr, m2_wr, a_wr, hop_wr, d, dir_pre_n, dir_m, dir_r, dir_a};
  assign outs = {cnt_pre_n, cnt_m, cnt_r, cnt_a, enh_out};

  // R11
  a_r11_reset_clears: assert property (@(posedge clk) rst |=> outs == '0);

  // R10
  a_r10_direct_pins: assert property (@(posedge clk) disable iff (rst)
    (ready && mode_direct) |=>
      (cnt_m == $past(dir_m) && cnt_r == $past(dir_r) &&
       cnt_a == $past(dir_a) && cnt_pre_n == $past(dir_pre_n)));

  // R12
  a_r12_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    (ready && $stable(inv) && $stable($past(inv))) |=> $stable(outs));

  // R2
  a_r2_serial_lsb: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(!mode_direct && mode_serial && sclk && !e_wr) && !$past(sclk, 2)
     && !mode_direct && mode_serial && sel_ser) |=> cnt_a[0] == $past(sdata, 2));

  // R3
  a_r3_serial_enh: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(!mode_direct && mode_serial && sclk && e_wr) && !$past(sclk, 2))
      |=> enh_out[0] == $past(sdata, 2));

  // R6
  a_r6_a_strobe: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(!mode_direct && !mode_serial && a_wr) && !$past(a_wr, 2)
     && !mode_direct && !mode_serial && sel_par) |=>
      (cnt_a == $past(d[3:0], 2) && cnt_r[3:0] == $past(d[7:4], 2)));
endmodule

bind synth_prog_if sp_chk u_chk (.*);

// File: tb/synth_prog_if_tb.sv
`timescale 1ns/1ps
module synth_prog_if_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic mode_direct = 0, mode_serial = 0, sel_ser = 0, sel_par = 0;
  logic sclk = 0, sdata = 0, e_wr = 0, m1_wr = 0, m2_wr = 0, a_wr = 0, hop_wr = 0;
  logic [7:0] d = '0;
  logic dir_pre_n = 0;
  logic [8:0] dir_m = '0;
  logic [5:0] dir_r = '0;
  logic [3:0] dir_a = '0;
  logic cnt_pre_n;
  logic [8:0] cnt_m;
  logic [5:0] cnt_r;
  logic [3:0] cnt_a;
  logic [7:0] enh_out;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  synth_prog_if u_dut (.*);

  // behavioural reference: words held as plain 20-bit vectors {pre,m,r,a}
  logic [19:0] m_prim, m_sec, m_out;
  logic [7:0]  m_enh, m_enh_out;
  logic [6:0]  m_prev;
  always @(posedge clk) begin
    logic [6:0] now, edg;
    logic [19:0] pn;
    now = {hop_wr, a_wr, m2_wr, m1_wr, e_wr, sclk, 1'b0};
    if (rst) begin
      m_prim = 0; m_sec = 0; m_enh = 0; m_out = 0; m_enh_out = 0; m_prev = 0;
    end else begin
      edg = now & ~m_prev;
      if (mode_direct)      m_out = {dir_pre_n, dir_m, dir_r, dir_a};
      else if (mode_serial) m_out = sel_ser ? m_prim : m_sec;
      else                  m_out = sel_par ? m_prim : m_sec;
      m_enh_out = m_enh;
      pn = m_prim;
      if (!mode_direct) begin
        if (edg[6]) m_sec = m_prim;
        if (mode_serial && edg[1]) begin
          if (e_wr) m_enh = {m_enh[6:0], sdata};
          else      pn = {m_prim[18:0], sdata};
        end
        if (!mode_serial) begin
          if (edg[3]) begin pn[19] = d[7]; pn[16:10] = d[6:0]; end
          if (edg[4]) begin pn[9:8] = d[3:2]; pn[18:17] = d[1:0]; end
          if (edg[5]) begin pn[7:4] = d[7:4]; pn[3:0] = d[3:0]; end
          if (edg[2]) m_enh = d;
        end
      end
      m_prim = pn;
      m_prev = now;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R12: model comparison on every cycle
  always @(negedge clk) if (!rst && !done)
    chk("R12 model", {cnt_pre_n, cnt_m, cnt_r, cnt_a, enh_out}, {m_out, m_enh_out});

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(int which);
    case (which)
      0: sclk = 1; 1: e_wr = 1; 2: m1_wr = 1; 3: m2_wr = 1; 4: a_wr = 1; default: hop_wr = 1;
    endcase
    tick(2);
    case (which)
      0: sclk = 0; 1: e_wr = 0; 2: m1_wr = 0; 3: m2_wr = 0; 4: a_wr = 0; default: hop_wr = 0;
    endcase
    tick(2);
  endtask

  task automatic ser_bits(logic [19:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      strobe(0);
    end
  endtask

  task automatic chk_word(string req, logic [19:0] exp);
    tick(2);
    chk(req, {cnt_pre_n, cnt_m, cnt_r, cnt_a}, exp);
  endtask

  localparam logic [19:0] W1 = {1'b1, 9'h1A5, 6'h2B, 4'h9};
  localparam logic [19:0] W2 = {1'b0, 9'h0C3, 6'h11, 4'h6};
  localparam logic [19:0] WP = {1'b1, 9'h185, 6'h27, 4'hE};
  localparam logic [19:0] WD = {1'b0, 9'h0F0, 6'h15, 4'h3};

  initial begin
    tick(3);
    chk("R11 reset", {cnt_pre_n, cnt_m, cnt_r, cnt_a, enh_out}, 0);
    rst = 0;
    tick(2);
    chk("R11 after reset", {cnt_pre_n, cnt_m, cnt_r, cnt_a, enh_out}, 0);

    // serial mode, primary selected
    mode_serial = 1; sel_ser = 1;
    ser_bits(W1, 20);
    chk_word("R2 serial word", W1);
    e_wr = 1; tick(2);
    ser_bits(20'hC3, 8);
    e_wr = 0; tick(2);
    chk("R3 serial enh", enh_out, 8'hC3);
    chk_word("R3 primary untouched", W1);

    // hop and select
    strobe(5);
    sel_ser = 0;
    chk_word("R8 hop copy", W1);
    ser_bits(W2, 20);
    chk_word("R9 secondary held", W1);
    sel_ser = 1;
    chk_word("R9 primary selected", W2);

    // bus strobes in serial mode do nothing
    d = 8'hFF; strobe(2); strobe(3); strobe(4);
    chk_word("R13 strobes ignored in serial", W2);

    // parallel mode
    mode_serial = 0; sel_par = 1;
    d = 8'h7E; strobe(4);
    chk("R6 A strobe", {cnt_r[3:0], cnt_a}, 8'h7E);
    d = 8'h0B; strobe(3);
    chk("R5 M2 strobe", {cnt_r[5:4], cnt_m[8:7]}, 4'hB);
    d = 8'h85; strobe(2);
    chk_word("R4 M1 strobe", WP);
    d = 8'h5A; strobe(1);
    chk("R7 parallel enh", enh_out, 8'h5A);
    sdata = 1; strobe(0); strobe(0);
    chk_word("R13 sclk ignored in parallel", WP);
    sel_par = 0;
    chk_word("R9 parallel secondary", W1);
    sel_par = 1;

    // direct mode, with mode_serial both ways
    dir_pre_n = 0; dir_m = 9'h0F0; dir_r = 6'h15; dir_a = 4'h3;
    mode_direct = 1;
    chk_word("R1 direct select", WD);
    mode_serial = 1;
    chk_word("R1 direct wins over serial", WD);
    d = 8'h00;
    strobe(0); strobe(5);
    mode_serial = 0;
    strobe(1); strobe(2); strobe(3); strobe(4); strobe(5);
    dir_a = 4'hC;
    chk_word("R10 pins follow", {1'b0, 9'h0F0, 6'h15, 4'hC});
    mode_direct = 0;
    chk_word("R10 primary preserved", WP);
    chk("R10 enh preserved", enh_out, 8'h5A);
    sel_par = 0;
    chk_word("R10 secondary preserved", W1);

    // hop in parallel mode
    strobe(5);
    chk_word("R8 hop in parallel", WP);

    // reset mid-run
    rst = 1; tick(2);
    chk("R11 reset clears", {cnt_pre_n, cnt_m, cnt_r, cnt_a, enh_out}, 0);
    rst = 0; sel_par = 1; tick(3);
    chk_word("R11 primary cleared", 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule